// File: doc/BRIEF.md
# ARINC 429 Receive Word Filter

This block sits between an ARINC 429 receive deserializer and the receive FIFO. Each time the deserializer presents a complete 32-bit word with a one-cycle valid strobe, the filter decides whether that word is offered to the FIFO. Several stages, each switched on by its own control bit, take part in that decision. The label byte can be bit-reversed. Words with bad odd parity can be dropped. The two source/destination bits can be required to match programmed values. The label can be looked up in a 256-entry enable table that the host writes and reads back one bit at a time.

In parallel, the block compares each word's label with three programmed priority labels. It copies each matching word into the corresponding mailbox register and raises that mailbox's full flag. The host clears the flag by strobing a read for that mailbox. A word that lands in a mailbox is still offered to the FIFO, subject to the label table. Every control bit resets to 0, so a freshly reset filter passes every word unchanged.

Word bit numbering follows the bus: bus bit 1 is `wordIn[0]` and bus bit 32 is `wordIn[31]`. The label occupies `wordIn[7:0]`.

Top module: `rx_word_filter`

## Requirements
- R1: After reset, `acceptValid`, `acceptWord`, `mbxFull` and `mbxData` are all zero. With `ctrlIn` equal to 0, every word strobed by `wordValid` appears unchanged on `acceptWord`, with `acceptValid` high for exactly the following cycle.
- R2: When `ctrlIn[0]` is set, the label is bit-reversed. `wordIn[7]` becomes bit 0 and `wordIn[0]` becomes bit 7. The reversed label is used by every filter and by both outputs. Bits 31..8 pass unchanged.
- R3: When `ctrlIn[4]` is set, a word is accepted only if the XOR of all 32 bits is 1 (odd parity, with bit 31 as the parity bit). When `ctrlIn[4]` is clear, parity is ignored.
- R4: When `ctrlIn[1]` is set, a word is accepted only if `wordIn[8]` equals `ctrlIn[2]` and `wordIn[9]` equals `ctrlIn[3]`.
- R5: When `ctrlIn[5]` is set, a word is accepted only if the table entry indexed by its label is 1. When `ctrlIn[5]` is clear, the table has no effect.
- R6: A cycle with `tblWrEn` high writes `tblWrData` into table entry `tblAddr`. `tblRdData` shows entry `tblAddr` one cycle later. All entries reset to 0.
- R7: When `ctrlIn[6]` is set, a word that passes the parity and source/destination checks is loaded into mailbox i, whose data is `mbxData[32i+31:32i]`, if its label equals `prioLabels[8i+7:8i]`. The load does not depend on the table. `mbxFull[i]` is set on the next cycle. A later matching word overwrites the mailbox, and every matching mailbox is loaded.
- R8: When `ctrlIn[6]` is clear, `mbxData` and `mbxFull` are not loaded.
- R9: A cycle with `mbxRead[i]` high clears `mbxFull[i]` on the next cycle. If a load of mailbox i happens in the same cycle, the load wins.
- R10: A word loaded into a mailbox is still offered to the FIFO under the same rules as any other word.
- R11: A rejected word, or a cycle without `wordValid`, leaves `acceptValid` low and `acceptWord` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| ctrlIn | input | 7 | Control bits: 0 label reverse, 1 SD match enable, 2 SD bit-9 value, 3 SD bit-10 value, 4 parity check, 5 label table enable, 6 priority mailboxes enable |
| wordValid | input | 1 | One-cycle strobe marking a new received word |
| wordIn | input | 32 | Received word, bus bit 1 in bit 0 |
| tblWrEn | input | 1 | Label table write strobe |
| tblAddr | input | 8 | Label table entry to write or read |
| tblWrData | input | 1 | Value written into the table entry |
| tblRdData | output | 1 | Table entry at `tblAddr`, one cycle later |
| prioLabels | input | 24 | Three priority labels, mailbox i in bits 8i+7..8i |
| acceptValid | output | 1 | Strobe to the FIFO: accepted word present |
| acceptWord | output | 32 | Accepted word |
| mbxRead | input | 3 | Per-mailbox read strobe that clears the full flag |
| mbxData | output | 96 | Mailbox contents, mailbox i in bits 32i+31..32i |
| mbxFull | output | 3 | Per-mailbox full flag |

## Verification
The assertions check, on every cycle, several invariants that hold whatever words arrive. With all control bits clear, each strobed word appears unchanged one cycle later. Every accepted word has odd parity while parity checking is on, and carries the programmed source/destination bits while that match is on. The FIFO strobe never rises without a preceding input strobe, and the mailboxes stay frozen while priority mode is off. Other behaviours depend on programmed state and need the directed scenarios to show them. These are label reversal, table-gated rejection, table read-back, mailbox loading, overwrite, the read that clears a full flag, and a mailbox word that the table keeps out of the FIFO.

// File: rtl/rx_filter_pkg.sv
package rx_filter_pkg;
  localparam int WORD_W   = 32;
  localparam int LABEL_W  = 8;
  localparam int NUM_MBX  = 3;
  localparam int TBL_SIZE = 1 << LABEL_W;
  localparam int CTRL_W   = 7;

  localparam int C_FLIP   = 0;
  localparam int C_SD_EN  = 1;
  localparam int C_SD9    = 2;
  localparam int C_SD10   = 3;
  localparam int C_PAR_EN = 4;
  localparam int C_TBL_EN = 5;
  localparam int C_PRI_EN = 6;

  localparam int SD9_POS  = 8;
  localparam int SD10_POS = 9;

  typedef struct packed {
    logic               accept;
    logic [NUM_MBX-1:0] mbxLoad;
  } filtStrobe_t;
endpackage

// File: rtl/rx_filter_ctrl.sv
module rx_filter_ctrl
  import rx_filter_pkg::*;
(
  input  logic [CTRL_W-1:0]          ctrlIn,
  input  logic                       wordValid,
  input  logic [WORD_W-1:0]          wordIn,
  input  logic [NUM_MBX*LABEL_W-1:0] prioLabels,
  input  logic                       tableBit,
  output logic [LABEL_W-1:0]         labelIdx,
  output logic [WORD_W-1:0]          fixedWord,
  output filtStrobe_t                strobe
);
  logic [LABEL_W-1:0] revLabel;
  logic parityOk, sdOk, frontPass;

  always_comb begin
    for (int b = 0; b < LABEL_W; b++) revLabel[b] = wordIn[LABEL_W-1-b];
  end

  assign labelIdx  = ctrlIn[C_FLIP] ? revLabel : wordIn[LABEL_W-1:0];
  assign fixedWord = {wordIn[WORD_W-1:LABEL_W], labelIdx};

  // odd parity over the whole word; reversal does not change it
  assign parityOk  = !ctrlIn[C_PAR_EN] || (^wordIn);
  assign sdOk      = !ctrlIn[C_SD_EN] ||
                     ((wordIn[SD9_POS] == ctrlIn[C_SD9]) && (wordIn[SD10_POS] == ctrlIn[C_SD10]));
  assign frontPass = wordValid && parityOk && sdOk;

  assign strobe.accept = frontPass && (!ctrlIn[C_TBL_EN] || tableBit);

  generate
    for (genvar i = 0; i < NUM_MBX; i++) begin : g_match
      assign strobe.mbxLoad[i] = frontPass && ctrlIn[C_PRI_EN] &&
                                 (labelIdx == prioLabels[i*LABEL_W +: LABEL_W]);
    end
  endgenerate
endmodule

// File: rtl/rx_filter_dp.sv
module rx_filter_dp
  import rx_filter_pkg::*;
(
  input  logic                      clk,
  input  logic                      rstN,
  input  filtStrobe_t               strobe,
  input  logic [LABEL_W-1:0]        labelIdx,
  input  logic [WORD_W-1:0]         fixedWord,
  input  logic                      tblWrEn,
  input  logic [LABEL_W-1:0]        tblAddr,
  input  logic                      tblWrData,
  input  logic [NUM_MBX-1:0]        mbxRead,
  output logic                      tableBit,
  output logic                      tblRdData,
  output logic                      acceptValid,
  output logic [WORD_W-1:0]         acceptWord,
  output logic [NUM_MBX*WORD_W-1:0] mbxData,
  output logic [NUM_MBX-1:0]        mbxFull
);
  logic [TBL_SIZE-1:0] labelTable;

  assign tableBit = labelTable[labelIdx];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      labelTable <= '0;
      tblRdData  <= 1'b0;
    end else begin
      if (tblWrEn) labelTable[tblAddr] <= tblWrData;
      tblRdData <= labelTable[tblAddr];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      acceptValid <= 1'b0;
      acceptWord  <= '0;
    end else begin
      acceptValid <= strobe.accept;
      if (strobe.accept) acceptWord <= fixedWord;
    end
  end

  generate
    for (genvar i = 0; i < NUM_MBX; i++) begin : g_mbx
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          mbxData[i*WORD_W +: WORD_W] <= '0;
          mbxFull[i]                  <= 1'b0;
        end else if (strobe.mbxLoad[i]) begin
          mbxData[i*WORD_W +: WORD_W] <= fixedWord;
          mbxFull[i]                  <= 1'b1;
        end else if (mbxRead[i]) begin
          mbxFull[i]                  <= 1'b0;
        end
      end
    end
  endgenerate
endmodule

// File: rtl/rx_word_filter.sv
module rx_word_filter
  import rx_filter_pkg::*;
(
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [CTRL_W-1:0]             ctrlIn,
  input  logic                          wordValid,
  input  logic [WORD_W-1:0]             wordIn,
  input  logic                          tblWrEn,
  input  logic [LABEL_W-1:0]            tblAddr,
  input  logic                          tblWrData,
  output logic                          tblRdData,
  input  logic [NUM_MBX*LABEL_W-1:0]    prioLabels,
  output logic                          acceptValid,
  output logic [WORD_W-1:0]             acceptWord,
  input  logic [NUM_MBX-1:0]            mbxRead,
  output logic [NUM_MBX*WORD_W-1:0]     mbxData,
  output logic [NUM_MBX-1:0]            mbxFull
);
  filtStrobe_t        strobe;
  logic [LABEL_W-1:0] labelIdx;
  logic [WORD_W-1:0]  fixedWord;
  logic               tableBit;

  rx_filter_ctrl u_ctrl (
    .ctrlIn(ctrlIn), .wordValid(wordValid), .wordIn(wordIn),
    .prioLabels(prioLabels), .tableBit(tableBit),
    .labelIdx(labelIdx), .fixedWord(fixedWord), .strobe(strobe)
  );

  rx_filter_dp u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .labelIdx(labelIdx),
    .fixedWord(fixedWord), .tblWrEn(tblWrEn), .tblAddr(tblAddr),
    .tblWrData(tblWrData), .mbxRead(mbxRead), .tableBit(tableBit),
    .tblRdData(tblRdData), .acceptValid(acceptValid), .acceptWord(acceptWord),
    .mbxData(mbxData), .mbxFull(mbxFull)
  );
endmodule

// File: rtl/rx_word_filter_chk.sv
module rx_word_filter_chk
  import rx_filter_pkg::*;
(
  input logic                          clk,
  input logic                          rstN,
  input logic [CTRL_W-1:0]             ctrlIn,
  input logic                          wordValid,
  input logic [WORD_W-1:0]             wordIn,
  input logic                          tblWrEn,
  input logic [LABEL_W-1:0]            tblAddr,
  input logic                          tblWrData,
  input logic                          tblRdData,
  input logic [NUM_MBX*LABEL_W-1:0]    prioLabels,
  input logic                          acceptValid,
  input logic [WORD_W-1:0]             acceptWord,
  input logic [NUM_MBX-1:0]            mbxRead,
  input logic [NUM_MBX*WORD_W-1:0]     mbxData,
  input logic [NUM_MBX-1:0]            mbxFull
);
  // R1
  bypass_pass_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(wordValid && (ctrlIn == '0)) |-> (acceptValid && (acceptWord == $past(wordIn))));

  // R3
  odd_parity_chk: assert property (@(posedge clk) disable iff (!rstN)
    (acceptValid && $past(ctrlIn[C_PAR_EN])) |-> (^acceptWord));

  // R4
  sd_match_chk: assert property (@(posedge clk) disable iff (!rstN)
    (acceptValid && $past(ctrlIn[C_SD_EN])) |->
      ((acceptWord[SD9_POS] == $past(ctrlIn[C_SD9])) && (acceptWord[SD10_POS] == $past(ctrlIn[C_SD10]))));

  // R11
  no_spurious_chk: assert property (@(posedge clk) disable iff (!rstN)
    acceptValid |-> $past(wordValid));

  // R8
  mbx_frozen_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$past(ctrlIn[C_PRI_EN]) |-> ((mbxData == $past(mbxData)) && !$rose(mbxFull[0]) &&
                                  !$rose(mbxFull[1]) && !$rose(mbxFull[2])));
endmodule

bind rx_word_filter rx_word_filter_chk u_chk (.*);

// File: tb/rx_word_filter_bench.sv
module rx_word_filter_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [6:0]  ctrlIn = '0;
  logic        wordValid = 1'b0;
  logic [31:0] wordIn = '0;
  logic        tblWrEn = 1'b0;
  logic [7:0]  tblAddr = '0;
  logic        tblWrData = 1'b0;
  logic        tblRdData;
  logic [23:0] prioLabels = '0;
  logic        acceptValid;
  logic [31:0] acceptWord;
  logic [2:0]  mbxRead = '0;
  logic [95:0] mbxData;
  logic [2:0]  mbxFull;

  int nChecks = 0;
  int nFails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_word_filter u_rx_word_filter (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] withOddPar(input logic [31:0] w);
    logic [31:0] r = w;
    r[31] = ~(^w[30:0]);
    return r;
  endfunction

  function automatic logic [7:0] rev8(input logic [7:0] x);
    logic [7:0] r;
    for (int b = 0; b < 8; b++) r[b] = x[7-b];
    return r;
  endfunction

  // drive one word; on return the registered result is visible
  task automatic sendWord(input logic [31:0] w);
    @(negedge clk); wordValid = 1'b1; wordIn = w;
    @(negedge clk); wordValid = 1'b0;
  endtask

  task automatic tblWrite(input logic [7:0] a, input logic d);
    @(negedge clk); tblWrEn = 1'b1; tblAddr = a; tblWrData = d;
    @(negedge clk); tblWrEn = 1'b0;
  endtask

  task automatic testReset();
    @(negedge clk);
    chk("R1 reset acceptValid", {31'b0, acceptValid}, 32'd0);
    chk("R1 reset mbxFull", {29'b0, mbxFull}, 32'd0);
    chk("R1 reset mbxData", mbxData[31:0] | mbxData[63:32] | mbxData[95:64], 32'd0);
    chk("R6 reset table", {31'b0, tblRdData}, 32'd0);
  endtask

  task automatic testBypass();
    ctrlIn = '0;
    sendWord(32'hDEAD_BEEF);
    chk("R1 bypass valid", {31'b0, acceptValid}, 32'd1);
    chk("R1 bypass word", acceptWord, 32'hDEAD_BEEF);
    sendWord(32'h0000_0000);  // even parity, still passes
    chk("R3 parity off pass", {31'b0, acceptValid}, 32'd1);
    @(negedge clk);
    chk("R11 idle no strobe", {31'b0, acceptValid}, 32'd0);
    chk("R11 idle word held", acceptWord, 32'h0000_0000);
  endtask

  task automatic testFlip();
    ctrlIn = 7'b000_0001;
    sendWord(32'h1234_5601);
    chk("R2 reversed label", acceptWord, {24'h123456, rev8(8'h01)});
    ctrlIn = '0;
  endtask

  task automatic testParity();
    logic [31:0] good = withOddPar(32'h0ABC_1234);
    ctrlIn = 7'b001_0000;
    sendWord(good);
    chk("R3 good parity accepted", {31'b0, acceptValid}, 32'd1);
    chk("R3 good parity word", acceptWord, good);
    sendWord(good ^ 32'h0000_0100);
    chk("R3 bad parity rejected", {31'b0, acceptValid}, 32'd0);
    chk("R11 rejected word held", acceptWord, good);
    ctrlIn = '0;
  endtask

  task automatic testSd();
    ctrlIn = 7'b000_0110;  // enable, bit9 value 1, bit10 value 0
    sendWord(32'h0000_0177);
    chk("R4 SD match accepted", {31'b0, acceptValid}, 32'd1);
    sendWord(32'h0000_0377);
    chk("R4 SD mismatch rejected", {31'b0, acceptValid}, 32'd0);
    ctrlIn = '0;
  endtask

  task automatic testTable();
    tblWrite(8'h25, 1'b1);
    @(negedge clk); tblAddr = 8'h25;
    @(negedge clk);
    chk("R6 table readback set", {31'b0, tblRdData}, 32'd1);
    tblAddr = 8'h26;
    @(negedge clk);
    chk("R6 table readback clear", {31'b0, tblRdData}, 32'd0);
    ctrlIn = 7'b010_0000;
    sendWord(32'h5555_5525);
    chk("R5 enabled label accepted", {31'b0, acceptValid}, 32'd1);
    sendWord(32'h5555_5526);
    chk("R5 disabled label rejected", {31'b0, acceptValid}, 32'd0);
    ctrlIn = 7'b010_0001;
    sendWord(32'h6666_66A4);  // reverses to 0x25
    chk("R2 reversed label filtered", {31'b0, acceptValid}, 32'd1);
    chk("R2 reversed label stored", acceptWord, 32'h6666_6625);
    ctrlIn = '0;
  endtask

  task automatic testPrio();
    prioLabels = {8'h33, 8'h25, 8'h11};
    ctrlIn = 7'b111_0000;  // priority, table, parity
    sendWord(withOddPar(32'h0100_0011));
    chk("R7 mailbox0 full", {29'b0, mbxFull}, 32'd1);
    chk("R7 mailbox0 data", mbxData[31:0], withOddPar(32'h0100_0011));
    chk("R10 table still gates fifo", {31'b0, acceptValid}, 32'd0);
    sendWord(withOddPar(32'h0200_0025));
    chk("R7 mailbox1 full", {29'b0, mbxFull}, 32'd3);
    chk("R10 mailbox word to fifo", acceptWord, withOddPar(32'h0200_0025));
    sendWord(withOddPar(32'h0300_0011) ^ 32'h8000_0000);
    chk("R7 bad parity no load", mbxData[31:0], withOddPar(32'h0100_0011));
    sendWord(withOddPar(32'h0400_0011));
    chk("R7 mailbox overwrite", mbxData[31:0], withOddPar(32'h0400_0011));
    @(negedge clk); mbxRead = 3'b001;
    @(negedge clk); mbxRead = 3'b000;
    chk("R9 read clears flag", {29'b0, mbxFull}, 32'd2);
    @(negedge clk); mbxRead = 3'b100; wordValid = 1'b1; wordIn = withOddPar(32'h0500_0033);
    @(negedge clk); mbxRead = 3'b000; wordValid = 1'b0;
    chk("R9 load beats read", {29'b0, mbxFull}, 32'd6);
    ctrlIn = 7'b001_0000;
    sendWord(withOddPar(32'h0600_0025));
    chk("R8 mode off no load", mbxData[63:32], withOddPar(32'h0200_0025));
    chk("R8 mode off flags", {29'b0, mbxFull}, 32'd6);
    ctrlIn = '0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testBypass();
    testFlip();
    testParity();
    testSd();
    testTable();
    testPrio();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule